// File: doc/BRIEF.md
# Fractional Feedback Divider Delta-Sigma Modulator

This block sets the divide value that a frequency synthesizer's feedback counter uses on each reference cycle. The average ratio is a fraction: an integer multiply value plus a fractional word scaled by 2^-F. A single integer divide value cannot give that ratio. The block therefore dithers the divide value from one reference cycle to the next. Three chained accumulators produce carry bits. A difference network combines these carries into a small signed correction, and that correction is added to the integer value. Its quantisation error is shaped towards high frequencies, where the loop filter removes it.

Software sets the integer value, the fractional word, the fraction width (8, 16, 24 or 32 bits) and the shaping order (off, first, second or third). The block advances one step on each reference tick and presents the divide value for that cycle in a register. If any setting changes, the modulator clears its state and starts again from zero.

Top module: `dsm_frac_mod`

## Requirements
- R1: While `rst` (synchronous, active high) is sampled high, `div_out` becomes 0 and all accumulators and carry history clear.
- R2: `fw_sel` selects the fraction width F: 0 gives 8, 1 gives 16, 2 gives 24 and 3 gives 32 bits. Only the low F bits of `k_frac` are used, and the accumulators hold F-bit values.
- R3: `order_sel` selects the shaping: 0 is off, 1 is first order, 2 is second order and 3 is third order. When the order is off or `en` is low, `div_out` equals `m_int` after every clock edge.
- R4: On a clock edge with `tick` high, `en` high, a nonzero order and no setting change, `div_out` becomes `m_int` + y. Each stage computes e_i = (e_i + in_i) mod 2^F with carry c_i. Stage 1 takes K, and stage i takes the new e_(i-1). The correction is y = c1 at first order, c1 + c2 − c2' at second order, and c1 + c2 − c2' + c3 − 2·c3' + c3'' at third order, where ' marks the value from the previous tick.
- R5: At first order, y is 0 or 1. Over 2^F consecutive ticks starting from the cleared state, the outputs sum to exactly M·2^F + (K mod 2^F). At second and third order the sum differs from that value by −1 to +2.
- R6: y stays within −1..+2 at second order and within −3..+4 at third order.
- R7: On a clock edge with `tick` low, `div_out` and the modulator state do not change.
- R8: A clock edge on which any of `en`, `m_int`, `k_frac`, `fw_sel` or `order_sel` differs from its value at the previous edge clears all state and sets `div_out` to `m_int`. A tick on that edge is discarded.
- R9: `div_out` is a 12-bit two's-complement value and is not clamped. With M = 1 at third order it can go negative.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Reference-cycle step strobe |
| en | input | 1 | Modulator enable |
| m_int | input | 10 | Integer multiply value, 1 to 512 |
| k_frac | input | 32 | Fractional word; low F bits used |
| fw_sel | input | 2 | Fraction width select |
| order_sel | input | 2 | Shaping order select |
| div_out | output | 12 | Signed divide value for the current reference cycle |

## Verification
The bench builds the block with its default widths. It runs most cases at the 8-bit fraction width, where one full period of 256 ticks is short. It sweeps all three orders over a set of fractional words for a whole period, so it can check every tick against an arithmetic model as well as the exact period sum. Shorter runs at the 16-, 24- and 32-bit widths exercise the carry position for each width. Separate cases test the wide word masking, the negative excursion with M = 1, M = 512, a held tick in the middle of a run and a setting change that arrives on a tick.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

    localparam int ACC_W  = 32;
    localparam int MULT_W = 10;
    localparam int OUT_W  = 12;
    localparam int CORR_W = 4;
    localparam int STAGES = 3;

    typedef enum logic [1:0] {
        ORD_OFF = 2'd0,
        ORD_1   = 2'd1,
        ORD_2   = 2'd2,
        ORD_3   = 2'd3
    } order_e;

    typedef enum logic [1:0] {
        FW_8  = 2'd0,
        FW_16 = 2'd1,
        FW_24 = 2'd2,
        FW_32 = 2'd3
    } fwidth_e;

    typedef struct packed {
        logic              en;
        logic [MULT_W-1:0] m;
        logic [ACC_W-1:0]  k;
        fwidth_e           fw;
        order_e            ord;
    } dsm_cfg_t;

    typedef struct packed {
        logic             carry;
        logic [ACC_W-1:0] sum;
    } acc_res_t;

    function automatic logic [ACC_W-1:0] fw_mask(fwidth_e fw);
        logic [ACC_W-1:0] m;
        case (fw)
            FW_8:    m = 32'h0000_00FF;
            FW_16:   m = 32'h0000_FFFF;
            FW_24:   m = 32'h00FF_FFFF;
            default: m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction

    // operands are already reduced to the selected width
    function automatic acc_res_t acc_add(logic [ACC_W-1:0] a,
                                         logic [ACC_W-1:0] b,
                                         fwidth_e fw);
        acc_res_t      r;
        logic [ACC_W:0] s;
        s = {1'b0, a} + {1'b0, b};
        case (fw)
            FW_8:    r.carry = s[8];
            FW_16:   r.carry = s[16];
            FW_24:   r.carry = s[24];
            default: r.carry = s[32];
        endcase
        r.sum = s[ACC_W-1:0] & fw_mask(fw);
        return r;
    endfunction

endpackage

// File: rtl/dsm_acc_stage.sv
module dsm_acc_stage
    import dsm_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             step,
    input  fwidth_e          fw,
    input  logic [ACC_W-1:0] in_word,
    output logic [ACC_W-1:0] acc_now,
    output logic             carry
);

    logic [ACC_W-1:0] acc_q;
    acc_res_t         res;

    assign res     = acc_add(acc_q, in_word, fw);
    assign acc_now = res.sum;
    assign carry   = res.carry;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            acc_q <= '0;
        end else if (step) begin
            acc_q <= res.sum;
        end
    end

    // R2
    no_overflow_chk: assert property (@(posedge clk) disable iff (rst || clr)
        (acc_q & ~fw_mask(fw)) == '0);

    // R8
    clear_chk: assert property (@(posedge clk) disable iff (rst)
        clr |=> (acc_q == '0));

    // R7
    acc_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !clr && !step) |=> $stable(acc_q));

endmodule

// File: rtl/dsm_noise_shaper.sv
module dsm_noise_shaper
    import dsm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     clr,
    input  logic                     step,
    input  order_e                   ord,
    input  logic [STAGES-1:0]        carries,
    output logic signed [CORR_W-1:0] corr
);

    logic c2_d, c3_d, c3_dd;
    logic signed [CORR_W-1:0] s1, s2, s2d, s3, s3d, s3dd;

    assign s1   = $signed({{(CORR_W-1){1'b0}}, carries[0]});
    assign s2   = $signed({{(CORR_W-1){1'b0}}, carries[1]});
    assign s3   = $signed({{(CORR_W-1){1'b0}}, carries[2]});
    assign s2d  = $signed({{(CORR_W-1){1'b0}}, c2_d});
    assign s3d  = $signed({{(CORR_W-1){1'b0}}, c3_d});
    assign s3dd = $signed({{(CORR_W-1){1'b0}}, c3_dd});

    always_comb begin
        case (ord)
            ORD_1:   corr = s1;
            ORD_2:   corr = s1 + s2 - s2d;
            ORD_3:   corr = s1 + s2 - s2d + s3 - (s3d <<< 1) + s3dd;
            default: corr = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            c2_d  <= 1'b0;
            c3_d  <= 1'b0;
            c3_dd <= 1'b0;
        end else if (step) begin
            c2_d  <= carries[1];
            c3_dd <= c3_d;
            c3_d  <= carries[2];
        end
    end

    // R5
    first_order_chk: assert property (@(posedge clk) disable iff (rst)
        (ord == ORD_1) |-> (corr >= 0 && corr <= 1));

    // R6
    second_order_chk: assert property (@(posedge clk) disable iff (rst)
        (ord == ORD_2) |-> (corr >= -1 && corr <= 2));

    // R6
    third_order_chk: assert property (@(posedge clk) disable iff (rst)
        (ord == ORD_3) |-> (corr >= -3 && corr <= 4));

endmodule

// File: rtl/dsm_frac_mod.sv
module dsm_frac_mod
    import dsm_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    tick,
    input  logic                    en,
    input  logic [MULT_W-1:0]       m_int,
    input  logic [ACC_W-1:0]        k_frac,
    input  logic [1:0]              fw_sel,
    input  logic [1:0]              order_sel,
    output logic signed [OUT_W-1:0] div_out
);

    localparam int EXT_W = OUT_W - MULT_W;

    dsm_cfg_t cur_cfg, cfg_q;
    logic     cfg_chg, active, clr, step;

    always_comb begin
        cur_cfg.en  = en;
        cur_cfg.m   = m_int;
        cur_cfg.k   = k_frac;
        cur_cfg.fw  = fwidth_e'(fw_sel);
        cur_cfg.ord = order_e'(order_sel);
    end

    always_ff @(posedge clk) begin
        if (rst) cfg_q <= '0;
        else     cfg_q <= cur_cfg;
    end

    assign cfg_chg = (cur_cfg != cfg_q);
    assign active  = en && (cur_cfg.ord != ORD_OFF);
    assign clr     = cfg_chg || !active;
    assign step    = tick && !clr;

    logic [ACC_W-1:0]  stage_in  [STAGES];
    logic [ACC_W-1:0]  stage_out [STAGES];
    logic [STAGES-1:0] carries;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stage_in[g] = k_frac & fw_mask(cur_cfg.fw);
        end else begin : g_tail
            assign stage_in[g] = stage_out[g-1];
        end
        dsm_acc_stage u_acc (
            .clk     (clk),
            .rst     (rst),
            .clr     (clr),
            .step    (step),
            .fw      (cur_cfg.fw),
            .in_word (stage_in[g]),
            .acc_now (stage_out[g]),
            .carry   (carries[g])
        );
    end

    logic signed [CORR_W-1:0] corr;

    dsm_noise_shaper u_shaper (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .step    (step),
        .ord     (cur_cfg.ord),
        .carries (carries),
        .corr    (corr)
    );

    logic signed [OUT_W-1:0] m_ext, corr_ext, m_q_ext;

    assign m_ext    = $signed({{EXT_W{1'b0}}, m_int});
    assign m_q_ext  = $signed({{EXT_W{1'b0}}, cfg_q.m});
    assign corr_ext = $signed({{(OUT_W-CORR_W){corr[CORR_W-1]}}, corr});

    always_ff @(posedge clk) begin
        if (rst) begin
            div_out <= '0;
        end else if (clr) begin
            div_out <= m_ext;
        end else if (step) begin
            div_out <= m_ext + corr_ext;
        end
    end

    // R6
    out_range_chk: assert property (@(posedge clk) disable iff (rst)
        (div_out >= m_q_ext - 12'sd3) && (div_out <= m_q_ext + 12'sd4));

    // R3
    disabled_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !active) |=> (div_out == $signed({{EXT_W{1'b0}}, $past(m_int)})));

    // R7
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!rst && !clr && !step) |=> $stable(div_out));

endmodule

// File: tb/dsm_frac_mod_tb.sv
module dsm_frac_mod_tb;

    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               tick = 1'b0;
    logic               en = 1'b0;
    logic [9:0]         m_int = '0;
    logic [31:0]        k_frac = '0;
    logic [1:0]         fw_sel = '0;
    logic [1:0]         order_sel = '0;
    logic signed [11:0] div_out;

    int  n_checks = 0;
    int  n_errors = 0;
    bit  done = 1'b0;

    always #10 clk = ~clk;

    dsm_frac_mod u_dut (
        .clk(clk), .rst(rst), .tick(tick), .en(en), .m_int(m_int),
        .k_frac(k_frac), .fw_sel(fw_sel), .order_sel(order_sel),
        .div_out(div_out)
    );

    // arithmetic model of the requirements
    longint e1, e2, e3, kk, md;
    int     c2d, c3d, c3dd, cur_ord;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int model_tick();
        longint s;
        int c1, c2, c3, y;
        s = e1 + kk; c1 = (s >= md) ? 1 : 0; e1 = s % md;
        s = e2 + e1; c2 = (s >= md) ? 1 : 0; e2 = s % md;
        s = e3 + e2; c3 = (s >= md) ? 1 : 0; e3 = s % md;
        case (cur_ord)
            1: y = c1;
            2: y = c1 + c2 - c2d;
            3: y = c1 + c2 - c2d + c3 - 2 * c3d + c3dd;
            default: y = 0;
        endcase
        c3dd = c3d; c3d = c3; c2d = c2;
        return y;
    endfunction

    task automatic model_clear(input int fw, input longint k);
        int fb;
        fb = 8 * (fw + 1);
        md = longint'(1) << fb;
        kk = k & (md - 1);
        e1 = 0; e2 = 0; e3 = 0; c2d = 0; c3d = 0; c3dd = 0;
    endtask

    // drop enable for one edge, then apply settings; R8 expects M after change
    task automatic configure(input int m, input longint k, input int fw, input int ord);
        @(negedge clk);
        en = 1'b0; tick = 1'b0;
        @(negedge clk);
        en = 1'b1; m_int = 10'(m); k_frac = 32'(k);
        fw_sel = 2'(fw); order_sel = 2'(ord);
        @(negedge clk);
        check(div_out == 12'(m), "R8 config clear", div_out, m);
        cur_ord = ord;
        model_clear(fw, k);
    endtask

    task automatic one_tick(input int m, output int act);
        int y;
        tick = 1'b1;
        @(negedge clk);
        tick = 1'b0;
        y = model_tick();
        act = int'(div_out);
        check(act == m + y, "R4 per-tick value", act, m + y);
        case (cur_ord)
            1: check(act - m >= 0 && act - m <= 1, "R5 first-order range", act - m, 0);
            2: check(act - m >= -1 && act - m <= 2, "R6 second-order range", act - m, 0);
            default: check(act - m >= -3 && act - m <= 4, "R6 third-order range", act - m, 0);
        endcase
    endtask

    task automatic run_case(input int m, input longint k, input int fw, input int ord,
                            input int n, input bit sum_chk, input bit hold_mid);
        longint sum;
        longint target;
        int act;
        configure(m, k, fw, ord);
        sum = 0;
        for (int i = 0; i < n; i++) begin
            if (hold_mid && i == n / 2) begin
                logic signed [11:0] held;
                held = div_out;
                for (int j = 0; j < 3; j++) begin
                    @(negedge clk);
                    check(div_out == held, "R7 hold without tick", div_out, held);
                end
            end
            one_tick(m, act);
            sum += act;
        end
        if (sum_chk) begin
            target = longint'(m) * n + kk;
            if (ord == 1)
                check(sum == target, "R5 exact period sum", sum, target);
            else
                check(sum - target >= -1 && sum - target <= 2, "R5 period sum residue", sum, target);
        end
    endtask

    initial begin
        int act;
        int klist [6] = '{1, 3, 85, 128, 200, 255};
        repeat (4) @(negedge clk);
        check(div_out == 0, "R1 reset output", div_out, 0);
        rst = 1'b0;

        // R5/R4: full-period sweeps at 8-bit width, all orders
        for (int o = 1; o <= 3; o++)
            foreach (klist[i])
                run_case(100, longint'(klist[i]), 0, o, 256, 1'b1, (i == 2));

        // R2: high bits of K ignored at 8-bit width
        run_case(37, 64'h0001_0003, 0, 1, 256, 1'b1, 1'b0);
        // R2: other widths
        run_case(200, 64'h1234, 1, 3, 600, 1'b0, 1'b0);
        run_case(20, 64'h0080_0001, 2, 2, 300, 1'b0, 1'b1);
        run_case(50, 64'h8000_0001, 3, 3, 300, 1'b0, 1'b0);
        run_case(50, 64'h8000_0000, 3, 1, 16, 1'b0, 1'b0);
        // R9: negative excursion, and the top of the M range
        run_case(1, 64'd128, 0, 3, 256, 1'b1, 1'b0);
        run_case(512, 64'd77, 0, 3, 256, 1'b1, 1'b0);

        // R8: change K on a tick edge; tick discarded, state restarts
        configure(60, 64'd90, 0, 3);
        for (int i = 0; i < 5; i++) one_tick(60, act);
        tick = 1'b1; k_frac = 32'd91;
        @(negedge clk);
        tick = 1'b0;
        check(div_out == 60, "R8 tick on change discarded", div_out, 60);
        model_clear(0, 64'd91);
        for (int i = 0; i < 20; i++) one_tick(60, act);

        // R3: order off holds M on ticks
        configure(45, 64'd100, 0, 0);
        for (int i = 0; i < 4; i++) begin
            tick = 1'b1;
            @(negedge clk);
            tick = 1'b0;
            check(div_out == 45, "R3 order off gives M", div_out, 45);
        end
        // R3: enable low gives M
        order_sel = 2'd3; en = 1'b0; m_int = 10'd300;
        for (int i = 0; i < 3; i++) begin
            tick = 1'b1;
            @(negedge clk);
            check(div_out == 300, "R3 enable low gives M", div_out, 300);
        end
        tick = 1'b0;

        // R1: reset mid-run
        rst = 1'b1;
        @(negedge clk);
        check(div_out == 0, "R1 reset mid-run", div_out, 0);
        rst = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

endmodule